// File: doc/BRIEF.md
# Framed Serial Sample Transmitter

This block sends parallel samples out over a three-wire synchronous serial link that is timed entirely from the master clock. Time is divided into fixed slots of four master clock cycles per sample bit: 64 cycles for the default 16-bit width. The block generates a serial clock at half the master rate, so every slot holds 32 serial clock periods. The sample goes out most significant bit first in the first half of the slot, and the data line is held at zero for the second half.

A frame sync output marks the slot boundaries in one of two shapes, chosen by a format input. In pulse format it is high for the last serial clock period of a slot, and it falls at the moment the first data bit appears. In level format it is low while data bits are sent and high for the zero half of the slot.

The upstream logic presents a sample with a one-cycle load strobe at any time. The block holds that sample and starts sending it at the next slot boundary. The previous word is sent again if no new sample has arrived. An output-enable input releases the data line to high impedance so that several transmitters can share one line.

Top module: `framed_serial_tx`

## Requirements
- R1: A slot lasts exactly 4*DATA_W master clock cycles (64 at DATA_W=16). Phase 0 is the cycle in which reset is released, and the phase advances by one each master clock cycle, wrapping from the last phase to 0.
- R2: `sclk_out` is low in even phases and high in odd phases. It therefore toggles on every master clock cycle and gives 2*DATA_W serial clock periods per slot.
- R3: In phases 2k and 2k+1 with k < DATA_W, the data line carries bit DATA_W-1-k of the current word, so the most significant bit comes first.
- R4: In phases 2k and 2k+1 with DATA_W <= k < 2*DATA_W, the data line is driven to 0.
- R5: When `fmt_level` = 0, `fsync_out` is high only in the last two phases of a slot, which is one serial clock period. It is low in every other phase, so it falls when the first data bit is presented.
- R6: When `fmt_level` = 1, `fsync_out` is low in the first half of the slot (phases below 2*DATA_W) and high in the second half.
- R7: While `out_en` = 0, `sdata_out` is high impedance. `sclk_out` and `fsync_out` keep running unchanged.
- R8: The data line changes only at the master clock edge on which `sclk_out` falls, so a receiver can sample it on the rising edge.
- R9: A sample loaded in any phase other than the last one does not change the slot in progress. It becomes the current word at the next slot boundary.
- R10: A sample loaded in the last phase of a slot is sent in the very next slot. If several loads arrive within one slot, the latest one is sent.
- R11: While `rst` is high, the phase is held at 0, `sclk_out` and `fsync_out` are low, the data line drives 0, and both the current and the pending word are cleared to zero.
- R12: If no sample is loaded during a slot, the next slot sends the same word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | DATA_W | Sample word to transmit |
| sample_load | input | 1 | One-cycle strobe that captures `sample_in` |
| fmt_level | input | 1 | Frame sync shape: 0 pulse, 1 level |
| out_en | input | 1 | 1 drives the data line, 0 releases it |
| sclk_out | output | 1 | Serial clock, half the master rate |
| fsync_out | output | 1 | Frame sync |
| sdata_out | output | 1 | Serial data, high impedance when disabled |

## Verification
The bench builds the block with the default DATA_W of 16, which gives a 64-cycle slot. At that width a few hundred cycles cover every phase of several consecutive slots, including the wrap from phase 63 to phase 0 where a new word takes over. Loads are placed at phase 5, at phase 63 and twice within one slot. This exercises both the hold-until-boundary rule and the last-load-wins rule. A pull-up on the bench's data wire makes the released line read as 1, so high impedance can be told apart from a driven zero in the tail half of a slot.

// File: rtl/sfo_pkg.sv
package sfo_pkg;

    typedef enum logic {
        FS_PULSE = 1'b0,
        FS_LEVEL = 1'b1
    } fs_mode_e;

    typedef struct packed {
        logic sclk;        // serial clock level for this phase
        logic slot_last;   // final master cycle of the slot
        logic final_per;   // final serial clock period of the slot
        logic tail;        // second half of slot (zero fill)
    } phase_flags_t;

    function automatic logic fs_value(fs_mode_e mode, phase_flags_t f);
        logic v;
        case (mode)
            FS_PULSE: v = f.final_per;
            default:  v = f.tail;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sfo_slot_timer.sv
module sfo_slot_timer
    import sfo_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int SLOT  = 4 * DATA_W,
    localparam int CNT_W = $clog2(SLOT)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output phase_flags_t     flags
);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(SLOT - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(SLOT - 2);
    localparam logic [CNT_W-1:0] HALF     = CNT_W'(2 * DATA_W);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    always_comb begin
        flags.sclk      = cnt[0];
        flags.slot_last = (cnt == LAST);
        flags.final_per = (cnt >= PRE_LAST);
        flags.tail      = (cnt >= HALF);
    end

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> (cnt == '0));

    // R1
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != LAST) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/sfo_word_stager.sv
module sfo_word_stager #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              sample_load,
    input  logic              slot_last,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] pending;
    logic [DATA_W-1:0] pending_d;

    always_comb begin
        pending_d = sample_load ? sample_in : pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            word    <= '0;
        end else begin
            pending <= pending_d;
            if (slot_last)
                word <= pending_d;
        end
    end

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_last |=> $stable(word));

    // R10
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_last && sample_load) |=> (word == $past(sample_in)));

endmodule

// File: rtl/sfo_bit_select.sv
module sfo_bit_select #(
    parameter int DATA_W = 16,
    localparam int SLOT  = 4 * DATA_W,
    localparam int CNT_W = $clog2(SLOT),
    localparam int IDX_W = CNT_W - 1
) (
    input  logic [DATA_W-1:0] word,
    input  logic [CNT_W-1:0]  cnt,
    output logic              data_bit
);
    localparam logic [IDX_W-1:0] BIT_LIM = IDX_W'(DATA_W);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        idx      = cnt[CNT_W-1:1];
        shifted  = word << idx;
        data_bit = (idx < BIT_LIM) ? shifted[DATA_W-1] : 1'b0;
    end

endmodule

// File: rtl/framed_serial_tx.sv
module framed_serial_tx
    import sfo_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              sample_load,
    input  logic              fmt_level,
    input  logic              out_en,
    output logic              sclk_out,
    output logic              fsync_out,
    output logic              sdata_out
);
    localparam int SLOT  = 4 * DATA_W;
    localparam int CNT_W = $clog2(SLOT);

    logic [CNT_W-1:0]  cnt;
    phase_flags_t      flags;
    logic [DATA_W-1:0] word;
    logic              data_bit;
    fs_mode_e          mode;

    sfo_slot_timer #(.DATA_W(DATA_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .cnt   (cnt),
        .flags (flags)
    );

    sfo_word_stager #(.DATA_W(DATA_W)) u_stager (
        .clk         (clk),
        .rst         (rst),
        .sample_in   (sample_in),
        .sample_load (sample_load),
        .slot_last   (flags.slot_last),
        .word        (word)
    );

    sfo_bit_select #(.DATA_W(DATA_W)) u_bits (
        .word     (word),
        .cnt      (cnt),
        .data_bit (data_bit)
    );

    always_comb begin
        mode      = fs_mode_e'(fmt_level);
        sclk_out  = flags.sclk;
        fsync_out = fs_value(mode, flags);
    end

    assign sdata_out = out_en ? data_bit : 1'bz;

    // R8
    data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_out) |-> $stable(data_bit));

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(fsync_out) && !fmt_level) |=> fsync_out);

endmodule

// File: tb/framed_serial_tx_test.sv
`timescale 1ns/1ps
module framed_serial_tx_test;
    localparam int DW   = 16;
    localparam int SLOT = 4 * DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] sample_in = '0;
    logic          sample_load = 1'b0;
    logic          fmt_level = 1'b0;
    logic          out_en = 1'b1;
    wire           sclk_w, fsync_w, sdata_w;

    pullup (sdata_w);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int            phase;
    logic [DW-1:0] m_word, m_pend;
    logic          prev_sd, prev_sclk;
    bit            prev_ok;

    always #2.5 clk = ~clk;

    framed_serial_tx #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .sample_in(sample_in), .sample_load(sample_load),
        .fmt_level(fmt_level), .out_en(out_en),
        .sclk_out(sclk_w), .fsync_out(fsync_w), .sdata_out(sdata_w)
    );

    task automatic cmp(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s phase=%0d actual=%b expected=%b", req, phase, act, exp);
        end
    endtask

    function automatic logic exp_data();
        int k = phase / 2;
        if (!out_en) return 1'b1;
        if (k < DW) return m_word[DW-1-k];
        return 1'b0;
    endfunction

    task automatic check_now();
        int k = phase / 2;
        cmp("R2", sclk_w, logic'(phase % 2));
        if (fmt_level) cmp("R6", fsync_w, logic'(phase >= 2*DW));
        else           cmp("R5", fsync_w, logic'(phase >= SLOT-2));
        if (!out_en)     cmp("R7", sdata_w, exp_data());
        else if (k < DW) cmp("R3", sdata_w, exp_data());
        else             cmp("R4", sdata_w, exp_data());
        if (prev_ok && out_en) begin
            checks++;
            if (sdata_w !== prev_sd && !(prev_sclk && !sclk_w)) begin
                fails++;
                $display("FAIL R8 phase=%0d actual=%b expected=%b", phase, sdata_w, prev_sd);
            end
        end
        prev_sd   = sdata_w;
        prev_sclk = sclk_w;
        prev_ok   = out_en;
    endtask

    // one master cycle, optional load during it
    task automatic tick(input logic ld, input logic [DW-1:0] val);
        sample_load = ld;
        sample_in   = val;
        @(negedge clk);
        if (ld) m_pend = val;
        if (phase == SLOT-1) m_word = m_pend;
        phase = (phase + 1) % SLOT;
        sample_load = 1'b0;
        check_now();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0);
    endtask

    task automatic run_to(input int p);
        while (phase != p) tick(1'b0, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        phase = 0; m_word = '0; m_pend = '0; prev_ok = 0;
        cmp("R11", sclk_w, 1'b0);
        cmp("R11", fsync_w, 1'b0);
        cmp("R11", sdata_w, 1'b0);
        rst = 1'b0;
        check_now();
    endtask

    task automatic t_reset();
        out_en = 1'b1; fmt_level = 1'b0;
        do_reset();
        tick(1'b1, 16'hFFFF);
        run_to(SLOT-1); run(5);
        // R11: reset mid-slot clears word and pending value
        do_reset();
        run(SLOT + 2);
    endtask

    task automatic t_level_frame();
        int rises = 0, last_rise = -1, cyc = 0;
        logic pf;
        fmt_level = 1'b1;
        do_reset();
        run_to(5);
        tick(1'b1, 16'hA5C3);      // R9: mid-slot load held
        pf = fsync_w;
        for (int i = 0; i < 3*SLOT; i++) begin
            tick(1'b0, '0);
            cyc++;
            if (fsync_w && !pf) begin
                if (last_rise >= 0) cmp("R1", logic'(cyc - last_rise == SLOT), 1'b1);
                last_rise = cyc; rises++;
            end
            pf = fsync_w;
        end
        cmp("R1", logic'(rises == 3), 1'b1);
    endtask

    task automatic t_pulse_frame();
        int width = 0;
        fmt_level = 1'b0;
        do_reset();
        tick(1'b1, 16'h8001);
        run_to(SLOT-3);
        for (int i = 0; i < 4; i++) begin
            tick(1'b0, '0);
            if (fsync_w) width++;
        end
        cmp("R5", logic'(width == 2), 1'b1);
        run(SLOT);
    endtask

    task automatic t_hiz();
        fmt_level = 1'b1;
        do_reset();
        tick(1'b1, 16'h0000);
        run_to(0);
        out_en = 1'b0;             // R7: released line reads pulled high
        run(SLOT);
        out_en = 1'b1;
        run(SLOT);
    endtask

    task automatic t_boundary();
        fmt_level = 1'b0;
        do_reset();
        run_to(SLOT-2);
        tick(1'b0, '0);
        tick(1'b1, 16'h3C96);      // R10: load in the last phase
        cmp("R10", sdata_w, 1'b0);  // MSB of 0x3C96 at phase 0
        run(2);
        tick(1'b1, 16'h1111);
        run(10);
        tick(1'b1, 16'hE00F);      // R10: latest of two loads wins
        run_to(0);
        cmp("R10", sdata_w, 1'b1);
        run(SLOT);
    endtask

    task automatic t_repeat();
        fmt_level = 1'b1;
        do_reset();
        tick(1'b1, 16'h5A5A);
        run_to(0);
        // R12: no further loads, same word in three slots
        run(3*SLOT);
        cmp("R12", logic'(m_word == 16'h5A5A), 1'b1);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        phase = 0; m_word = '0; m_pend = '0; prev_ok = 0;
        prev_sd = 1'b0; prev_sclk = 1'b0;
        @(negedge clk);
        t_reset();
        t_level_frame();
        t_pulse_frame();
        t_hiz();
        t_boundary();
        t_repeat();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule